// File: doc/BRIEF.md
# Four-State Moore Sequence Controller

This block is a small Moore-style controller that watches a single serial input bit and produces a single output flag. It keeps one of four states in a two-bit register and moves between them on every rising clock edge. The output flag is decoded from the stored state alone, so a change on the input shows up on the flag no earlier than the clock edge after it.

The four states are named `ST_REST` (code 0), `ST_ARMED` (code 1), `ST_HOLD` (code 2) and `ST_TAIL` (code 3). `ST_REST` and `ST_TAIL` raise the flag, and `ST_ARMED` and `ST_HOLD` lower it. The transitions are:

- `ST_REST`: input 0 stays in `ST_REST`, input 1 goes to `ST_ARMED`.
- `ST_ARMED`: input 0 goes back to `ST_REST`, input 1 stays in `ST_ARMED`.
- `ST_HOLD`: input 0 goes to `ST_ARMED`, input 1 stays in `ST_HOLD`.
- `ST_TAIL`: input 0 goes to `ST_REST`, input 1 goes to `ST_HOLD`.

`ST_HOLD` and `ST_TAIL` cannot be reached from reset. A preload port exists so that a test can place the register in any state. A synchronous reset returns the machine to `ST_REST`. The reset wins over the preload, and the preload wins over the normal transition. The current state code is also driven out on a debug port.

Top module: `moore4_ctrl`

## Requirements
- R1: When `rst` is high at a rising edge, the state after that edge is `ST_REST` (code 0), whatever `preload_en` and `a_in` are doing.
- R2: The state code on `state_dbg` is 0 for `ST_REST`, 1 for `ST_ARMED`, 2 for `ST_HOLD` and 3 for `ST_TAIL`.
- R3: From `ST_REST`, an edge with `a_in`=0 keeps `ST_REST`, and an edge with `a_in`=1 moves to `ST_ARMED`.
- R4: From `ST_ARMED`, an edge with `a_in`=0 moves to `ST_REST`, and an edge with `a_in`=1 keeps `ST_ARMED`.
- R5: From `ST_HOLD`, an edge with `a_in`=0 moves to `ST_ARMED`, and an edge with `a_in`=1 keeps `ST_HOLD`.
- R6: From `ST_TAIL`, an edge with `a_in`=0 moves to `ST_REST`, and an edge with `a_in`=1 moves to `ST_HOLD`.
- R7: `z_out` is 1 in `ST_REST` and `ST_TAIL` and 0 in `ST_ARMED` and `ST_HOLD`. A change of `a_in` between clock edges has no effect on `z_out`.
- R8: When `preload_en` is high and `rst` is low at an edge, the next state is the code on `preload_state`, whatever `a_in` is.
- R9: After reset, with `preload_en` held low, the state code never becomes 2 or 3 for any `a_in` sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 1 | Serial input bit that steers the transitions |
| preload_en | input | 1 | Test hook: loads `preload_state` at the next edge |
| preload_state | input | 2 | State code to load |
| z_out | output | 1 | Moore output flag |
| state_dbg | output | 2 | Current state code |

## Verification
The bench first preloads each of the four states and applies each input value, so every cell of the transition table and every output value is checked once. Next, the input is toggled in the middle of a clock period in every state; this shows whether the output follows the state or leaks the input. A long random input stream from reset is then compared cycle by cycle against a reference table, and the bench records whether a code of 2 or 3 ever appears. Last, reset and preload are applied together and then each alone, to confirm which one takes priority.

// File: rtl/moore4_pkg.sv
package moore4_pkg;
    localparam int STATE_W = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_REST  = 2'd0,
        ST_ARMED = 2'd1,
        ST_HOLD  = 2'd2,
        ST_TAIL  = 2'd3
    } state_t;
endpackage

// File: rtl/moore4_next.sv
module moore4_next
    import moore4_pkg::*;
(
    input  state_t cur_st,
    input  logic   a_in,
    output state_t nxt_st
);
    always_comb begin
        nxt_st = cur_st;
        unique case (cur_st)
            ST_REST:  nxt_st = a_in ? ST_ARMED : ST_REST;
            ST_ARMED: nxt_st = a_in ? ST_ARMED : ST_REST;
            ST_HOLD:  nxt_st = a_in ? ST_HOLD  : ST_ARMED;
            ST_TAIL:  nxt_st = a_in ? ST_HOLD  : ST_REST;
        endcase
    end
endmodule

// File: rtl/moore4_streg.sv
module moore4_streg
    import moore4_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load_en,
    input  logic [STATE_W-1:0] load_code,
    input  state_t             nxt_st,
    output state_t             cur_st
);
    always_ff @(posedge clk) begin
        if (rst)
            cur_st <= ST_REST;
        else if (load_en)
            cur_st <= state_t'(load_code);
        else
            cur_st <= nxt_st;
    end
endmodule

// File: rtl/moore4_out.sv
module moore4_out
    import moore4_pkg::*;
(
    input  state_t cur_st,
    output logic   z
);
    always_comb begin
        z = 1'b0;
        unique case (cur_st)
            ST_REST:  z = 1'b1;
            ST_ARMED: z = 1'b0;
            ST_HOLD:  z = 1'b0;
            ST_TAIL:  z = 1'b1;
        endcase
    end
endmodule

// File: rtl/moore4_ctrl.sv
module moore4_ctrl
    import moore4_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               a_in,
    input  logic               preload_en,
    input  logic [STATE_W-1:0] preload_state,
    output logic               z_out,
    output logic [STATE_W-1:0] state_dbg
);
    state_t cur_st;
    state_t nxt_st;

    moore4_next u_next (
        .cur_st (cur_st),
        .a_in   (a_in),
        .nxt_st (nxt_st)
    );

    moore4_streg u_reg (
        .clk       (clk),
        .rst       (rst),
        .load_en   (preload_en),
        .load_code (preload_state),
        .nxt_st    (nxt_st),
        .cur_st    (cur_st)
    );

    moore4_out u_out (
        .cur_st (cur_st),
        .z      (z_out)
    );

    assign state_dbg = cur_st;
endmodule

// File: rtl/moore4_chk.sv
module moore4_chk (
    input logic       clk,
    input logic       rst,
    input logic       a_in,
    input logic       preload_en,
    input logic [1:0] preload_state,
    input logic       z_out,
    input logic [1:0] state_dbg
);
    // R1
    reset_to_rest_chk: assert property (@(posedge clk)
        rst |=> state_dbg == 2'd0);

    // R8
    preload_wins_chk: assert property (@(posedge clk) disable iff (rst)
        preload_en |=> state_dbg == $past(preload_state));

    // R3
    rest_moves_chk: assert property (@(posedge clk) disable iff (rst)
        (!preload_en && state_dbg == 2'd0) |=> state_dbg == ($past(a_in) ? 2'd1 : 2'd0));

    // R4
    armed_moves_chk: assert property (@(posedge clk) disable iff (rst)
        (!preload_en && state_dbg == 2'd1) |=> state_dbg == ($past(a_in) ? 2'd1 : 2'd0));

    // R5
    hold_moves_chk: assert property (@(posedge clk) disable iff (rst)
        (!preload_en && state_dbg == 2'd2) |=> state_dbg == ($past(a_in) ? 2'd2 : 2'd1));

    // R6
    tail_moves_chk: assert property (@(posedge clk) disable iff (rst)
        (!preload_en && state_dbg == 2'd3) |=> state_dbg == ($past(a_in) ? 2'd2 : 2'd0));

    // R7
    flag_decode_chk: assert property (@(posedge clk) disable iff (rst)
        z_out == (state_dbg == 2'd0 || state_dbg == 2'd3));

    // R7
    flag_follows_state_chk: assert property (@(posedge clk) disable iff (rst)
        $stable(state_dbg) |-> $stable(z_out));

    // R9
    no_reach_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (!preload_en && state_dbg[1] == 1'b0) |=> state_dbg[1] == 1'b0);
endmodule

bind moore4_ctrl moore4_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .a_in          (a_in),
    .preload_en    (preload_en),
    .preload_state (preload_state),
    .z_out         (z_out),
    .state_dbg     (state_dbg)
);

// File: tb/sim_moore4_ctrl.sv
`timescale 1ns/1ps
module sim_moore4_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       a_in = 1'b0;
    logic       preload_en = 1'b0;
    logic [1:0] preload_state = 2'd0;
    logic       z_out;
    logic [1:0] state_dbg;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [1:0] ref_st = 2'd0;

    always #2.5 clk = ~clk;

    moore4_ctrl u0 (
        .clk(clk), .rst(rst), .a_in(a_in),
        .preload_en(preload_en), .preload_state(preload_state),
        .z_out(z_out), .state_dbg(state_dbg)
    );

    function automatic logic [1:0] ref_next(input logic [1:0] s, input logic a);
        case (s)
            2'd0:    return a ? 2'd1 : 2'd0;
            2'd1:    return a ? 2'd1 : 2'd0;
            2'd2:    return a ? 2'd2 : 2'd1;
            default: return a ? 2'd2 : 2'd0;
        endcase
    endfunction

    function automatic logic ref_z(input logic [1:0] s);
        return (s == 2'd0) || (s == 2'd3);
    endfunction

    task automatic check(input string req, input logic [1:0] exp_st);
        checks++;
        if (state_dbg !== exp_st || z_out !== ref_z(exp_st)) begin
            errors++;
            $display("FAIL %s: state=%0d z=%0b expected state=%0d z=%0b",
                     req, state_dbg, z_out, exp_st, ref_z(exp_st));
        end
    endtask

    // drive inputs just after a falling edge, apply one rising edge, return at the next falling edge
    task automatic step(input logic r, input logic pl, input logic [1:0] pls, input logic a);
        rst = r; preload_en = pl; preload_state = pls; a_in = a;
        if (r)       ref_st = 2'd0;
        else if (pl) ref_st = pls;
        else         ref_st = ref_next(ref_st, a);
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        step(1'b1, 1'b0, 2'd0, 1'b0);
        check("R1 reset state", 2'd0);
        step(1'b1, 1'b0, 2'd0, 1'b1);
        check("R1 reset with a_in high", 2'd0);

        // full table sweep: every state by preload, every input value (R2..R6)
        for (int s = 0; s < 4; s++) begin
            for (int a = 0; a < 2; a++) begin
                step(1'b0, 1'b1, 2'(s), 1'b1);
                check("R8 preload", 2'(s));
                check("R2 code and flag", 2'(s));
                step(1'b0, 1'b0, 2'd0, 1'(a));
                case (s)
                    0: check("R3 rest transition", ref_st);
                    1: check("R4 armed transition", ref_st);
                    2: check("R5 hold transition", ref_st);
                    default: check("R6 tail transition", ref_st);
                endcase
            end
        end

        // mid-cycle input toggles must not reach the flag (R7)
        for (int s = 0; s < 4; s++) begin
            step(1'b0, 1'b1, 2'(s), 1'b0);
            preload_en = 1'b0;
            for (int t = 0; t < 3; t++) begin
                a_in = ~a_in;
                #0.4;
                check("R7 flag ignores a_in", 2'(s));
            end
        end

        // reset priority over preload (R1, R8)
        step(1'b0, 1'b1, 2'd3, 1'b0);
        step(1'b1, 1'b1, 2'd2, 1'b1);
        check("R1 reset beats preload", 2'd0);
        step(1'b0, 1'b1, 2'd2, 1'b0);
        check("R8 preload beats transition", 2'd2);

        // random stream from reset, no preload (R3, R4, R7, R9)
        step(1'b1, 1'b0, 2'd0, 1'b0);
        begin
            int upper_seen = 0;
            for (int i = 0; i < 2000; i++) begin
                step(1'b0, 1'b0, 2'd0, 1'($urandom_range(0, 1)));
                check("R3/R4 random stream", ref_st);
                if (state_dbg[1]) upper_seen++;
            end
            checks++;
            if (upper_seen != 0) begin
                errors++;
                $display("FAIL R9: upper states seen %0d times expected 0", upper_seen);
            end
        end

        // random stream with occasional preload into unreachable states (R5, R6, R8)
        for (int i = 0; i < 2000; i++) begin
            logic pl;
            pl = ($urandom_range(0, 7) == 0);
            step(1'b0, pl, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
            check("R5/R6/R8 mixed stream", ref_st);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule